// File: doc/BRIEF.md
# Partial Reconfiguration Load Port

A synthesizable behavioural model of a device configuration port, meant to stand in for the real port in RTL simulations of a design that swaps modules at run time. A byte stream enters over a valid/ready handshake. It carries a reduced configuration image. The image is addressed by a region identifier and a module identifier rather than by physical frame coordinates. The port checks the image, and when the image is complete and intact it switches the region's output multiplexer to the module that the image names.

While an image is loading, the region's output toward the static logic is not the selected module's data. It is a deliberately corrupted alternating pattern. This makes any missing isolation in the surrounding logic visible. If the checksum is wrong, the header is wrong, or a new sync word appears in the middle of a load, the load is abandoned. The previous module stays in place and a one-cycle error flag is raised.

Top module: `prcfg_port`

## Requirements
- R1: During and right after reset, `active_mod` is 0, `load_busy` is 0, `load_err` is 0, and `cfg_ready` is 1.
- R2: A load frame consists of these bytes in order: the sync bytes 0xAA, 0x99, 0x55, 0x66; one header byte with the region ID in bits 7:4 and the module ID in bits 3:0; a 16-bit payload length sent high byte first; the payload bytes; and one checksum byte. The checksum equals the XOR of the header byte, both length bytes and all payload bytes. When a matching checksum byte is accepted, `active_mod` shows the header's module ID from the next cycle onward.
- R3: When the checksum byte does not match, `active_mod` keeps its previous value and `load_err` is high for exactly one cycle, namely the cycle after that byte is accepted.
- R4: When the header's region ID differs from the `REGION_ID` parameter, or its module ID is NUM_MOD or larger, the load is abandoned as soon as the header byte is accepted. The behaviour is the same as in R3.
- R5: When the four most recent bytes accepted during a load form the sync word, the load is abandoned. The behaviour is the same as in R3.
- R6: `load_busy` goes high in the cycle after the last sync byte is accepted. It stays high until the frame ends. It is high for one more cycle after the commit or abort edge and low in the cycle after that.
- R7: `cfg_ready` is low in the two cycles that follow sync detection and in the one cycle that follows a commit or an abort. It is high at all other times.
- R8: While `load_busy` is high, `region_dout` is 0xDEAD in the first busy cycle. After that it alternates between 0xBEEF and 0xDEAD on every clock.
- R9: While `load_busy` is low, `region_dout` equals slice `active_mod` of `mod_dout`. Slice i occupies bits i*16 to i*16+15.
- R10: Bytes that arrive outside a load and do not complete a sync word have no effect. Cycles in which `cfg_valid` is low stall the load without changing it.
- R11: A frame with a length of 0 places the checksum byte directly after the length bytes and commits in the normal way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration byte valid |
| cfg_data | input | 8 | Configuration byte |
| cfg_ready | output | 1 | Port can accept a byte |
| mod_dout | input | NUM_MOD*DATA_W | Outputs of the candidate modules, packed |
| region_dout | output | DATA_W | Region output to the static logic |
| active_mod | output | MOD_W | Currently selected module |
| load_busy | output | 1 | Load in progress |
| load_err | output | 1 | One-cycle pulse on an abandoned load |

## Verification
The frame table covers the following cases:
- Good frames of different lengths, which tell a correct commit apart from one taken from the wrong header field.
- A frame with one checksum bit flipped.
- A frame with a foreign region ID.
- A frame with an out-of-range module ID.
- An empty payload, which separates the direct length-to-checksum path from the payload path.

Directed sequences handle the remaining cases:
- A sync word embedded mid-payload, which must abort the load rather than restart it.
- Stray bytes between frames, including a partial sync.
- A frame sent with idle gaps, which shows that stalls are harmless.

Timing of the busy and ready edges around sync detection and commit is checked cycle by cycle.

// File: rtl/prcfg_pkg.sv
`timescale 1ns/1ps
package prcfg_pkg;

    localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
    localparam int          LEN_W     = 16;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HOLD,
        ST_HDR,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_PAY,
        ST_CSUM,
        ST_DONE
    } ld_state_e;

    typedef struct packed {
        logic [3:0] region;
        logic [3:0] module_id;
    } hdr_t;

    function automatic logic sync_match(input logic [23:0] hist, input logic [7:0] b);
        return {hist, b} == SYNC_WORD;
    endfunction

endpackage

// File: rtl/prcfg_parser.sv
`timescale 1ns/1ps
module prcfg_parser
    import prcfg_pkg::*;
#(
    parameter logic [3:0] REGION_ID = 4'h3,
    parameter int         NUM_MOD   = 4,
    parameter int         MOD_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             busy,
    output logic             commit,
    output logic [MOD_W-1:0] commit_mod,
    output logic             err
);

    ld_state_e        state;
    logic [23:0]      hist;
    logic             hold_cnt;
    hdr_t             hdr_q;
    logic [LEN_W-1:0] remain;
    logic [7:0]       csum;

    logic accept, sync_hit, loading, early, hdr_bad, abort;

    always_comb begin
        in_ready = !(state == ST_HOLD || state == ST_DONE);
        busy     = (state != ST_HUNT);
        accept   = in_valid && in_ready;
        sync_hit = accept && sync_match(hist, in_data);
        loading  = (state == ST_HDR) || (state == ST_LEN_HI) || (state == ST_LEN_LO) ||
                   (state == ST_PAY) || (state == ST_CSUM);
        early    = sync_hit && loading;
        hdr_bad  = (in_data[7:4] != REGION_ID) || (int'(in_data[3:0]) >= NUM_MOD);
        abort    = accept && (early ||
                              (state == ST_HDR  && hdr_bad) ||
                              (state == ST_CSUM && in_data != csum));
        commit   = accept && (state == ST_CSUM) && !early && (in_data == csum);
        commit_mod = hdr_q.module_id[MOD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            hist     <= '0;
            hold_cnt <= 1'b0;
            hdr_q    <= '0;
            remain   <= '0;
            csum     <= '0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            if (accept) begin
                if ((state == ST_HUNT && sync_hit) || abort || commit)
                    hist <= '0;
                else
                    hist <= {hist[15:0], in_data};
            end
            if (abort) begin
                state <= ST_DONE;
                err   <= 1'b1;
            end else begin
                unique case (state)
                    ST_HUNT: if (sync_hit) begin
                        state    <= ST_HOLD;
                        hold_cnt <= 1'b0;
                    end
                    ST_HOLD: begin
                        if (hold_cnt) state <= ST_HDR;
                        hold_cnt <= 1'b1;
                    end
                    ST_HDR: if (accept) begin
                        hdr_q <= hdr_t'(in_data);
                        csum  <= in_data;
                        state <= ST_LEN_HI;
                    end
                    ST_LEN_HI: if (accept) begin
                        remain[15:8] <= in_data;
                        csum         <= csum ^ in_data;
                        state        <= ST_LEN_LO;
                    end
                    ST_LEN_LO: if (accept) begin
                        remain[7:0] <= in_data;
                        csum        <= csum ^ in_data;
                        state       <= ({remain[15:8], in_data} == '0) ? ST_CSUM : ST_PAY;
                    end
                    ST_PAY: if (accept) begin
                        remain <= remain - 1'b1;
                        csum   <= csum ^ in_data;
                        if (remain == LEN_W'(1)) state <= ST_CSUM;
                    end
                    ST_CSUM: if (commit) state <= ST_DONE;
                    ST_DONE: state <= ST_HUNT;
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // R7: ready held low across the two cycles after sync detection
    p_hold_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !in_ready);
    p_hold_second_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> !in_ready);
    // R6: busy lasts exactly one cycle beyond a commit or abort
    p_busy_tail_r6: assert property (@(posedge clk) disable iff (rst)
        (commit || abort) |=> (busy ##1 !busy));

endmodule

// File: rtl/prcfg_region_iso.sv
`timescale 1ns/1ps
module prcfg_region_iso #(
    parameter int                NUM_MOD = 4,
    parameter int                DATA_W  = 16,
    parameter int                MOD_W   = 2,
    parameter logic [DATA_W-1:0] PAT_A   = 16'hDEAD,
    parameter logic [DATA_W-1:0] PAT_B   = 16'hBEEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      busy,
    input  logic [MOD_W-1:0]          sel,
    input  logic [NUM_MOD*DATA_W-1:0] mod_dout,
    output logic [DATA_W-1:0]         region_dout
);

    logic [DATA_W-1:0] slice [NUM_MOD];
    logic              phase;

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_slice
        assign slice[g] = mod_dout[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) phase <= 1'b0;
        else              phase <= ~phase;
    end

    always_comb begin
        if (busy) region_dout = phase ? PAT_B : PAT_A;
        else      region_dout = slice[sel];
    end

    // R8: first busy cycle shows the first pattern, then it changes every clock
    p_first_pat_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> region_dout == PAT_A);
    p_alternate_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> region_dout != $past(region_dout));

endmodule

// File: rtl/prcfg_port.sv
`timescale 1ns/1ps
module prcfg_port #(
    parameter logic [3:0] REGION_ID = 4'h3,
    parameter int         NUM_MOD   = 4,
    parameter int         DATA_W    = 16,
    parameter int         RESET_MOD = 0,
    parameter int         MOD_W     = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_valid,
    input  logic [7:0]                cfg_data,
    output logic                      cfg_ready,
    input  logic [NUM_MOD*DATA_W-1:0] mod_dout,
    output logic [DATA_W-1:0]         region_dout,
    output logic [MOD_W-1:0]          active_mod,
    output logic                      load_busy,
    output logic                      load_err
);

    logic             commit;
    logic [MOD_W-1:0] commit_mod;

    prcfg_parser #(
        .REGION_ID (REGION_ID),
        .NUM_MOD   (NUM_MOD),
        .MOD_W     (MOD_W)
    ) parser_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (cfg_valid),
        .in_data    (cfg_data),
        .in_ready   (cfg_ready),
        .busy       (load_busy),
        .commit     (commit),
        .commit_mod (commit_mod),
        .err        (load_err)
    );

    always_ff @(posedge clk) begin
        if (rst)         active_mod <= MOD_W'(RESET_MOD);
        else if (commit) active_mod <= commit_mod;
    end

    prcfg_region_iso #(
        .NUM_MOD (NUM_MOD),
        .DATA_W  (DATA_W),
        .MOD_W   (MOD_W)
    ) iso_i (
        .clk         (clk),
        .rst         (rst),
        .busy        (load_busy),
        .sel         (active_mod),
        .mod_dout    (mod_dout),
        .region_dout (region_dout)
    );

    // R3: error pulse is one cycle wide and leaves the selection untouched
    p_err_single_r3: assert property (@(posedge clk) disable iff (rst)
        load_err |=> !load_err);
    p_keep_on_err_r3: assert property (@(posedge clk) disable iff (rst)
        load_err |-> active_mod == $past(active_mod));
    // R2: the selection only moves at the end of a load
    p_swap_in_load_r2: assert property (@(posedge clk) disable iff (rst)
        (active_mod != $past(active_mod)) |-> load_busy);

endmodule

// File: tb/prcfg_port_tb.sv
`timescale 1ns/1ps
module prcfg_port_tb_top;

    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        cfg_ready;
    logic [63:0] mod_dout = {16'h1003, 16'h1002, 16'h1001, 16'h1000};
    logic [15:0] region_dout;
    logic [1:0]  active_mod;
    logic        load_busy;
    logic        load_err;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    logic ph = 1'b0;
    logic [1:0] exp_mod = 2'd0;

    // {header, length, checksum corruption}
    localparam logic [31:0] VEC [NV] = '{
        {8'h32, 16'd5,  8'h00},
        {8'h31, 16'd1,  8'h00},
        {8'h33, 16'd8,  8'h01},
        {8'h53, 16'd4,  8'h00},
        {8'h30, 16'd12, 8'h00},
        {8'h37, 16'd3,  8'h00},
        {8'h33, 16'd0,  8'h00},
        {8'h32, 16'd20, 8'h00}
    };

    always #4 clk = ~clk;

    prcfg_port dut_i (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
        .cfg_ready(cfg_ready), .mod_dout(mod_dout), .region_dout(region_dout),
        .active_mod(active_mod), .load_busy(load_busy), .load_err(load_err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pattern (R8) and pass-through (R9) monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (load_err) err_seen++;
            if (load_busy) begin
                chk(region_dout == (ph ? 16'hBEEF : 16'hDEAD), "R8 pattern",
                    region_dout, ph ? 16'hBEEF : 16'hDEAD);
                ph = ~ph;
            end else begin
                ph = 1'b0;
                chk(region_dout == 16'h1000 + 16'(exp_mod), "R9 pass-through",
                    region_dout, 16'h1000 + 16'(exp_mod));
            end
        end
    end

    // called at a negedge, returns at the negedge after the byte is accepted
    task automatic put(input logic [7:0] b);
        cfg_valid = 1'b1;
        cfg_data  = b;
        while (!cfg_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cfg_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic put_sync();
        put(8'hAA); put(8'h99); put(8'h55); put(8'h66);
    endtask

    task automatic send_frame(input logic [7:0] hdr, input logic [15:0] len,
                              input logic [7:0] cbad, input int seed, input bit gaps);
        logic [7:0] c;
        c = hdr ^ len[15:8] ^ len[7:0];
        put_sync();
        put(hdr);        if (gaps) idle(2);
        put(len[15:8]);  if (gaps) idle(1);
        put(len[7:0]);
        for (int i = 0; i < int'(len); i++) begin
            logic [7:0] p;
            p = 8'(i * 3 + 16 + seed);
            c ^= p;
            put(p);
            if (gaps) idle(2);
        end
        put(c ^ cbad);
        idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        // R1 reset state, observed during reset and after release
        chk(active_mod == 0, "R1 mod in reset", active_mod, 0);
        chk(load_busy == 0, "R1 busy in reset", load_busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(active_mod == 0, "R1 mod", active_mod, 0);
        chk(load_busy == 0 && load_err == 0, "R1 busy/err", {load_busy, load_err}, 0);
        chk(cfg_ready == 1, "R1 ready", cfg_ready, 1);

        // R10 stray bytes outside a load, including a partial sync
        put(8'h00); put(8'hAA); put(8'h99); put(8'h55); put(8'h12); put(8'h66);
        idle(2);
        chk(load_busy == 0, "R10 stray busy", load_busy, 0);
        chk(active_mod == 0 && err_seen == 0, "R10 stray effect", active_mod, 0);

        // R6/R7 timing around sync and commit, short frame to module 1
        put_sync();
        chk(load_busy == 1, "R6 busy after sync", load_busy, 1);
        chk(cfg_ready == 0, "R7 ready low 1", cfg_ready, 0);
        @(negedge clk);
        chk(cfg_ready == 0, "R7 ready low 2", cfg_ready, 0);
        @(negedge clk);
        chk(cfg_ready == 1, "R7 ready back", cfg_ready, 1);
        put(8'h31); put(8'h00); put(8'h00);
        cfg_valid = 1'b1; cfg_data = 8'h31;
        @(posedge clk); @(negedge clk);
        cfg_valid = 1'b0;
        exp_mod = 2'd1;
        chk(active_mod == 1, "R2 commit mod", active_mod, 1);
        chk(load_busy == 1, "R6 busy tail", load_busy, 1);
        chk(cfg_ready == 0, "R7 ready low after commit", cfg_ready, 0);
        @(negedge clk);
        chk(load_busy == 0, "R6 busy fall", load_busy, 0);
        chk(cfg_ready == 1, "R7 ready idle", cfg_ready, 1);

        // R5 sync word embedded in payload aborts
        e0 = err_seen;
        put_sync(); put(8'h32); put(8'h00); put(8'h0A); put(8'h01); put(8'h02);
        put(8'hAA); put(8'h99); put(8'h55);
        cfg_valid = 1'b1; cfg_data = 8'h66;
        @(posedge clk); @(negedge clk);
        cfg_valid = 1'b0;
        chk(load_err == 1, "R5 err pulse", load_err, 1);
        chk(active_mod == 1, "R5 mod kept", active_mod, 1);
        @(negedge clk);
        chk(load_err == 0 && load_busy == 0, "R5 end", {load_err, load_busy}, 0);
        chk(err_seen - e0 == 1, "R5 err count", err_seen - e0, 1);

        // table of frames: R2 commits, R3 checksum, R4 header, R11 empty
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  h;
            logic [15:0] l;
            logic [7:0]  cb;
            bit          ok;
            h  = VEC[v][31:24];
            l  = VEC[v][23:8];
            cb = VEC[v][7:0];
            ok = (h[7:4] == 4'h3) && (h[3:0] < 4) && (cb == 0);
            e0 = err_seen;
            send_frame(h, l, cb, v, 1'b0);
            if (ok) exp_mod = h[1:0];
            idle(3);
            chk(active_mod == exp_mod, ok ? "R2/R11 frame mod" : "R3/R4 frame mod kept",
                active_mod, exp_mod);
            chk(err_seen - e0 == (ok ? 0 : 1), "R3/R4 err count", err_seen - e0, ok ? 0 : 1);
            chk(load_busy == 0, "R6 idle after frame", load_busy, 0);
        end

        // R10 stalls inside a load
        e0 = err_seen;
        send_frame(8'h31, 16'd6, 8'h00, 9, 1'b1);
        exp_mod = 2'd1;
        idle(2);
        chk(active_mod == 1, "R10 gapped frame mod", active_mod, 1);
        chk(err_seen == e0, "R10 gapped frame err", err_seen - e0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule